// File: doc/BRIEF.md
# Dual Down-Counting Timer with Interrupt Unit

This peripheral holds two identical down-counting timers behind a 32-bit register port. Each timer keeps a reload value, a live count and a control word. The control word enables counting and picks one of four tick sources; each source is a one-cycle enable pulse supplied from outside. A timer whose count is already zero reloads from its reload value when the next selected tick arrives, and at that moment it raises its own raw interrupt bit.

The raw bits are sticky. Software clears them by writing ones to an acknowledge register, and gates them with a mask register. A read-only status register returns the raw bits ANDed with the mask. A single level interrupt output is high while any masked bit is set.

The register port is a plain, always-ready control interface. A write takes effect on the clock edge where `reg_valid` and `reg_write` are both high. Read data is combinational from the address while `reg_valid` is high and `reg_write` is low; otherwise it is zero. The port has no back-pressure.

Top module: `dual_tick_timer`

## Requirements
- R1: Byte map. Timer 0 has its reload value at 0x00, its live count at 0x04 (read-only) and its control word at 0x08. Timer 1 uses 0x10, 0x14 and 0x18. The mask is at 0x48 and reads back. The acknowledge register is at 0x4C, is write-only and reads as 0. The masked status is at 0x54 (read-only). Any other aligned address in the window reads 0.
- R2: Control word layout: bits [2:0] hold the source code and bit 4 is the run bit; all other bits read as 0. Codes 4, 5, 6 and 7 select `tick_src[0]`, `[1]`, `[2]` and `[3]`. Any other code never counts, even with run set.
- R3: While running, each pulse on the selected source decrements a nonzero count by one. The new count reads back from the next cycle.
- R4: With run clear, or with a pulse on a source that is not selected, the count holds.
- R5: A selected pulse that arrives while the count is 0 reloads the count from the reload value and sets a raw bit: bit 0 for timer 0, bit 1 for timer 1. The period is therefore reload+1 pulses. A raw bit stays set until it is acknowledged.
- R6: Writing a reload value also loads the count with the written value. Writing a control word loads the count with the stored reload value. A register write wins over a tick in the same cycle.
- R7: Writing the acknowledge register clears each raw bit whose position is 1 in the written value. An expiry in the same cycle keeps its bit set.
- R8: Bits [1:0] of the masked status equal raw AND mask. `irq_o` is high exactly when the masked status is nonzero.
- R9: After reset, all counts, reload values, control words, raw bits and the mask are zero, and `irq_o` is low.
- R10: A write with `reg_addr[1:0]` nonzero, or with an address of 0x5C or above, changes nothing. A read at such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| tick_src | input | 4 | Tick enable pulses, one per source |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench makes a timer expire from a count of zero and confirms that the count reloads and the raw bit sets on that same pulse. A design with an off-by-one terminal test would show a count of wrapped ones, or would fire one pulse early. The bench pulses unselected sources, runs a timer with an invalid source code, and ticks a stopped timer. A design with a loose source decode would drift its count in these cases. The bench also collides a reload write with a tick, and writes to an unaligned address and to one beyond the window. A design with the wrong write priority would read back one less than the written value, and one that ignores alignment would corrupt the reload value. Finally, the bench moves the mask while a raw bit stays pending, which shows whether the interrupt follows the gating or latches.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int TMR_STRIDE   = 'h10;
  localparam int OFF_RELOAD   = 'h00;
  localparam int OFF_COUNT    = 'h04;
  localparam int OFF_CTRL     = 'h08;
  localparam int ADDR_MASK    = 'h48;
  localparam int ADDR_ACK     = 'h4C;
  localparam int ADDR_STATUS  = 'h54;
  localparam int WIN_END      = 'h5C;
  localparam int SRC_BASE     = 4;   // first source code that maps to tick_src[0]
  localparam int CTRL_RUN_BIT = 4;
  localparam int SEL_W        = 3;

  function automatic int tmr_addr(int idx, int off);
    return idx * TMR_STRIDE + off;
  endfunction
endpackage

// File: rtl/dtt_timer.sv
module dtt_timer
  import dtt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_reload,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  wsel,
  input  logic              wrun,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic [DATA_W-1:0] reload_o,
  output logic [DATA_W-1:0] count_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              run_o,
  output logic              step_o,
  output logic              hit_o
);
  logic [DATA_W-1:0] reload_q, count_q;
  logic [SEL_W-1:0]  sel_q;
  logic              run_q;
  logic              step;

  // decode the source code into one tick enable
  always_comb begin
    step = 1'b0;
    for (int s = 0; s < NUM_SRC; s++)
      if (int'(sel_q) == SRC_BASE + s && tick_i[s]) step = run_q;
  end

  assign hit_o = step && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      sel_q    <= '0;
      run_q    <= 1'b0;
    end else if (wr_reload) begin
      reload_q <= wdata;
      count_q  <= wdata;
    end else if (wr_ctrl) begin
      sel_q   <= wsel;
      run_q   <= wrun;
      count_q <= reload_q;
    end else if (hit_o) begin
      count_q <= reload_q;
    end else if (step) begin
      count_q <= count_q - 1'b1;
    end
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign sel_o    = sel_q;
  assign run_o    = run_q;
  assign step_o   = step;
endmodule

// File: rtl/dtt_irq.sv
module dtt_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_i,
  input  logic         wr_mask,
  input  logic         wr_ack,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] masked_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q, mask_q, clr;

  assign clr = wr_ack ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr) | hit_i;   // an expiry beats the acknowledge
      if (wr_mask) mask_q <= wbits;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int N_TMR   = 2,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] tick_src,
  output logic               irq_o
);
  localparam int CTRL_PAD = DATA_W - CTRL_RUN_BIT - 1;
  localparam int STAT_PAD = DATA_W - N_TMR;

  logic wr_ok, rd_ok, wr_mask, wr_ack;
  logic [N_TMR-1:0] wr_reload, wr_ctrl, step_all, hit_all, run_all;
  logic [N_TMR-1:0][DATA_W-1:0] cnt_all, reload_all;
  logic [N_TMR-1:0][SEL_W-1:0]  sel_all;
  logic [N_TMR-1:0] raw, mask, masked;

  assign wr_ok   = reg_valid && reg_write && (reg_addr[1:0] == 2'b00)
                   && (int'(reg_addr) < WIN_END);
  assign rd_ok   = reg_valid && !reg_write;
  assign wr_mask = wr_ok && (int'(reg_addr) == ADDR_MASK);
  assign wr_ack  = wr_ok && (int'(reg_addr) == ADDR_ACK);

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    assign wr_reload[i] = wr_ok && (int'(reg_addr) == tmr_addr(i, OFF_RELOAD));
    assign wr_ctrl[i]   = wr_ok && (int'(reg_addr) == tmr_addr(i, OFF_CTRL));

    dtt_timer #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_reload(wr_reload[i]),
      .wr_ctrl  (wr_ctrl[i]),
      .wdata    (reg_wdata),
      .wsel     (reg_wdata[SEL_W-1:0]),
      .wrun     (reg_wdata[CTRL_RUN_BIT]),
      .tick_i   (tick_src),
      .reload_o (reload_all[i]),
      .count_o  (cnt_all[i]),
      .sel_o    (sel_all[i]),
      .run_o    (run_all[i]),
      .step_o   (step_all[i]),
      .hit_o    (hit_all[i])
    );
  end

  dtt_irq #(.N(N_TMR)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit_all),
    .wr_mask (wr_mask),
    .wr_ack  (wr_ack),
    .wbits   (reg_wdata[N_TMR-1:0]),
    .raw_o   (raw),
    .mask_o  (mask),
    .masked_o(masked),
    .irq_o   (irq_o)
  );

  // read mux: only exact aligned matches return data
  always_comb begin
    reg_rdata = '0;
    if (rd_ok) begin
      for (int i = 0; i < N_TMR; i++) begin
        if (int'(reg_addr) == tmr_addr(i, OFF_RELOAD)) reg_rdata = reload_all[i];
        if (int'(reg_addr) == tmr_addr(i, OFF_COUNT))  reg_rdata = cnt_all[i];
        if (int'(reg_addr) == tmr_addr(i, OFF_CTRL))
          reg_rdata = {{CTRL_PAD{1'b0}}, run_all[i], {(CTRL_RUN_BIT-SEL_W){1'b0}}, sel_all[i]};
      end
      if (int'(reg_addr) == ADDR_MASK)   reg_rdata = {{STAT_PAD{1'b0}}, mask};
      if (int'(reg_addr) == ADDR_STATUS) reg_rdata = {{STAT_PAD{1'b0}}, masked};
    end
  end
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
  parameter int N = 2,
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              any_wr,
  input logic              wr_ack,
  input logic [N-1:0]      ack_bits,
  input logic [N-1:0]      step,
  input logic [N-1:0]      hit,
  input logic [N-1:0][W-1:0] cnt,
  input logic [N-1:0]      raw,
  input logic [N-1:0]      mask,
  input logic              irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_chk
    // R4: no step and no write leaves the count alone
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!step[i] && !any_wr) |=> $stable(cnt[i]));
    // R3: a step from a nonzero count decrements by one
    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step[i] && cnt[i] != '0 && !any_wr) |=> (cnt[i] == $past(cnt[i]) - 1'b1));
    // R5: an expiry sets the raw bit
    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> raw[i]);
    // R5: raw bits are sticky until acknowledged
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[i] && !(wr_ack && ack_bits[i])) |=> raw[i]);
    // R7: acknowledge clears a bit unless an expiry collides
    p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && ack_bits[i] && !hit[i]) |=> !raw[i]);
  end
  // R8: the interrupt follows the masked raw bits
  p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & mask) != '0) |-> irq_o);
  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);
endmodule

bind dual_tick_timer dtt_checker #(.N(N_TMR), .W(DATA_W)) u_dtt_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .any_wr  (reg_valid && reg_write),
  .wr_ack  (wr_ack),
  .ack_bits(reg_wdata[N_TMR-1:0]),
  .step    (step_all),
  .hit     (hit_all),
  .cnt     (cnt_all),
  .raw     (raw),
  .mask    (mask),
  .irq_o   (irq_o)
);

// File: tb/dual_tick_timer_bench.sv
module dual_tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  tick_src = '0;
  logic        irq_o;

  int compared = 0, mismatched = 0;
  logic mon_req = 1'b0;
  bit   done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    bit          is_irq;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;   // 50 MHz

  dual_tick_timer u_dual_tick_timer (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_src(tick_src), .irq_o(irq_o));

  // monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (mon_req && sb_q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it  = sb_q.pop_front();
      got = it.is_irq ? {31'd0, irq_o} : reg_rdata;
      compared++;
      if (got !== it.exp) begin
        mismatched++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, got, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d, input int src);
    @(negedge clk); #1;
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    tick_src[src] = 1'b1;
    @(negedge clk); #1;
    reg_valid = 1'b0; reg_write = 1'b0; tick_src = '0;
  endtask

  task automatic tick(input int src, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1; tick_src[src] = 1'b1;
      @(negedge clk); #1; tick_src = '0;
    end
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); #1;
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    sb_q.push_back('{exp: e, is_irq: 1'b0, tag: tag});
    mon_req = 1'b1;
    @(negedge clk); #1;
    mon_req = 1'b0; reg_valid = 1'b0;
  endtask

  task automatic irq_exp(input logic e, input string tag);
    @(negedge clk); #1;
    sb_q.push_back('{exp: {31'd0, e}, is_irq: 1'b1, tag: tag});
    mon_req = 1'b1;
    @(negedge clk); #1;
    mon_req = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R9 reset state
    rd_exp(8'h04, 0, "R9 count0 after reset");
    rd_exp(8'h08, 0, "R9 ctrl0 after reset");
    rd_exp(8'h54, 0, "R9 status after reset");
    irq_exp(1'b0, "R9 irq after reset");

    // R1 / R6 reload write
    wr(8'h00, 3);
    rd_exp(8'h00, 3, "R1 reload0 readback");
    rd_exp(8'h04, 3, "R6 reload write loads count");
    tick(0, 1);
    rd_exp(8'h04, 3, "R4 stopped timer holds");

    // R2 control layout, source decode
    wr(8'h08, 32'h14);
    rd_exp(8'h08, 32'h14, "R2 ctrl readback");
    tick(1, 1);
    rd_exp(8'h04, 3, "R2 unselected source ignored");
    tick(0, 2);
    rd_exp(8'h04, 1, "R3 two pulses decrement");

    // R5 / R8 terminal and interrupt
    wr(8'h48, 3);
    tick(0, 1);
    rd_exp(8'h04, 0, "R3 count reaches zero");
    irq_exp(1'b0, "R5 no expiry at zero yet");
    tick(0, 1);
    rd_exp(8'h04, 3, "R5 reload on pulse at zero");
    rd_exp(8'h54, 1, "R5 raw bit0 set");
    irq_exp(1'b1, "R8 irq high");
    rd_exp(8'h48, 3, "R1 mask readback");
    tick(0, 1);
    rd_exp(8'h54, 1, "R5 raw bit sticky");

    // R7 acknowledge
    wr(8'h4C, 1);
    rd_exp(8'h54, 0, "R7 ack clears bit0");
    irq_exp(1'b0, "R7 irq low after ack");
    rd_exp(8'h4C, 0, "R1 ack reads zero");

    // timer 1, R5 bit1, R8 mask gating
    wr(8'h10, 0);
    wr(8'h18, 32'h17);
    tick(3, 1);
    rd_exp(8'h14, 0, "R5 reload zero period one");
    rd_exp(8'h54, 2, "R5 raw bit1 set");
    wr(8'h48, 1);
    rd_exp(8'h54, 0, "R8 masked off");
    irq_exp(1'b0, "R8 irq gated");
    wr(8'h48, 2);
    irq_exp(1'b1, "R8 irq follows mask");
    wr(8'h4C, 2);
    irq_exp(1'b0, "R7 ack bit1");

    // R6 write beats tick, control write reloads
    wr_tick(8'h10, 6, 3);
    rd_exp(8'h14, 6, "R6 write wins over tick");
    tick(3, 2);
    rd_exp(8'h14, 4, "R3 timer1 decrement");
    wr(8'h18, 32'h17);
    rd_exp(8'h14, 6, "R6 ctrl write reloads");

    // R2 invalid code with run set
    wr(8'h08, 32'h13);
    tick(0, 1); tick(1, 1); tick(2, 1); tick(3, 1);
    rd_exp(8'h04, 3, "R2 code 3 never counts");

    // R10 unaligned and out of window
    wr(8'h01, 32'hFF);
    rd_exp(8'h00, 3, "R10 unaligned write ignored");
    rd_exp(8'h01, 0, "R10 unaligned read zero");
    wr(8'h5C, 32'hFF);
    rd_exp(8'h5C, 0, "R10 out of window read zero");
    rd_exp(8'h48, 2, "R10 mask untouched");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule